// File: doc/BRIEF.md
# Timer Host Bus Front End

This block sits between a host bus and the three counting channels of a programmable interval timer. The host sees four byte-wide ports behind a two-bit address, qualified by active-low chip select, read and write strobes. Three of the ports belong to the channels. The fourth port is write-only and carries control traffic. The block samples the bus in the system clock domain. It turns each access into single-cycle strobes for the channel concerned: load an initial-count byte, program a new operating mode, freeze the running count, or advance to the next read byte.

The control port carries three kinds of traffic, and the top two bits of the written byte pick the kind. The values 0 to 2 name a channel. For a named channel, a zero access field freezes that channel's count, and any other access field reprograms the channel. The value 3 turns the byte into a read-back request that can cover several channels. The block normalises the mode field before the channels see it. It does not count, and it does not format read-back status.

Top module: `tmr_host_front`

## Requirements
- R1: While `cs_n` is high, the read and write strobes have no effect: no strobe output pulses and `dout_oe` stays low.
- R2: A write to address n (0, 1 or 2) produces exactly one pulse on `load_stb[n]`, one cycle long, with `wr_byte` equal to the written byte. No other strobe pulses.
- R3: A write to address 3 with bits 7:6 = n (0 to 2) and bits 5:4 non-zero produces one pulse on `prog_stb[n]`. During the pulse, `cw_access` equals bits 5:4 (1 = low byte only, 2 = high byte only, 3 = low then high) and `cw_bcd` equals bit 0.
- R4: During a `prog_stb` pulse, `cw_mode` is the 3-bit field in bits 3:1, except that 3'b110 gives 2 and 3'b111 gives 3. Values 0 to 5 pass unchanged, so `cw_mode` never exceeds 5.
- R5: A write to address 3 with bits 7:6 = n (0 to 2) and bits 5:4 = 0 produces one pulse on `latch_stb[n]` only. No `prog_stb` pulses, whatever bits 3:0 hold.
- R6: A write to address 3 with bits 7:6 = 3 produces one pulse on `rb_stb` and no channel strobe. During the pulse, `rb_sel[k]` = bit k+1, `rb_count` = NOT bit 5 and `rb_status` = NOT bit 4.
- R7: While `cs_n` and `rd_n` are both low with address n (0 to 2), `dout_oe` is high and `dout` equals byte n of `chan_rdata` (bits 8n+7:8n). When that read ends, exactly one pulse appears on `rbyte_stb[n]`.
- R8: A read at address 3 leaves `dout_oe` low and `dout` zero, and produces no strobe.
- R9: A strobe pulse appears in the cycle after the first clock edge that samples the access as active. An access held active for many cycles still gives one pulse. While `rst_n` is low, all strobes stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Port select: 0 to 2 channels, 3 control |
| din | input | 8 | Write data from host |
| chan_rdata | input | 24 | Current read byte of each channel, channel n in bits 8n+7:8n |
| dout | output | 8 | Read data to host |
| dout_oe | output | 1 | Read data output enable |
| wr_byte | output | 8 | Byte captured with the current write strobe |
| load_stb | output | 3 | Per-channel initial-count byte strobe |
| prog_stb | output | 3 | Per-channel mode programming strobe |
| latch_stb | output | 3 | Per-channel count freeze strobe |
| rbyte_stb | output | 3 | Per-channel read-byte-consumed strobe |
| cw_mode | output | 3 | Normalised operating mode for `prog_stb` |
| cw_access | output | 2 | Byte access pattern for `prog_stb` |
| cw_bcd | output | 1 | Decimal counting flag for `prog_stb` |
| rb_stb | output | 1 | Read-back request strobe |
| rb_sel | output | 3 | Channels named by the read-back request |
| rb_count | output | 1 | Read-back asks for the count to be frozen |
| rb_status | output | 1 | Read-back asks for status to be frozen |

## Verification
Two conditions are hard to reach from the ports. One is a single access held low for many clock cycles. The other is a read whose end comes from chip select rising rather than from the read strobe. In both cases the edge detector must give exactly one strobe. The stimulus holds writes for a long stretch and ends one read by raising only `cs_n`. Around each access it counts every strobe pulse over the whole window, so a repeated or missing pulse shows up as a wrong count. The control-port vectors cover each selector value and each access code, including both folded mode encodings and a freeze command with non-zero mode bits.

// File: rtl/tmr_front_pkg.sv
// Shared constants, types and helpers for the timer host front end.
// Assumes a byte-wide host bus and an 8-bit control word layout.
package tmr_front_pkg;

    localparam int BUS_W = 8;

    // Byte access pattern carried in bits 5:4 of a control word.
    typedef enum logic [1:0] {
        ACC_FREEZE = 2'b00,
        ACC_LOW    = 2'b01,
        ACC_HIGH   = 2'b10,
        ACC_BOTH   = 2'b11
    } acc_e;

    // Field view of a control byte, most significant field first.
    typedef struct packed {
        logic [1:0] target;
        acc_e       access;
        logic [2:0] mode;
        logic       bcd;
    } ctl_byte_t;

    // Fold the two aliased encodings onto modes 2 and 3.
    function automatic logic [2:0] fold_mode(input logic [2:0] raw);
        fold_mode = raw[1] ? {1'b0, raw[1:0]} : raw;
    endfunction

endpackage

// File: rtl/tmr_bus_sampler.sv
// Samples the asynchronous host strobes in the system clock domain and
// turns each access into a single-cycle event. A write event fires on the
// first sampled active cycle and carries the address and data seen there.
// A read event fires once the read is no longer active and carries the
// last address seen while it was active.
// Assumes the host holds address and data stable for the sampled cycle.
module tmr_bus_sampler #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_evt,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_evt,
    output logic [ADDR_W-1:0] rd_addr
);

    logic wr_act_q, wr_act_d;
    logic rd_act_q, rd_act_d;
    logic [ADDR_W-1:0] wr_addr_q, rd_addr_q;
    logic [DATA_W-1:0] wr_data_q;

    // Sample qualified write activity and its address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act_q  <= 1'b0;
            wr_act_d  <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_act_q  <= ~cs_n & ~wr_n;
            wr_act_d  <= wr_act_q;
            wr_addr_q <= addr;
            wr_data_q <= din;
        end
    end

    // Sample qualified read activity and hold the address while it is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_act_q  <= 1'b0;
            rd_act_d  <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            rd_act_q <= ~cs_n & ~rd_n;
            rd_act_d <= rd_act_q;
            if (!cs_n && !rd_n) begin
                rd_addr_q <= addr;
            end
        end
    end

    // Edge events: a write starts, a read finishes.
    always_comb begin
        wr_evt  = wr_act_q & ~wr_act_d;
        rd_evt  = ~rd_act_q & rd_act_d;
        wr_addr = wr_addr_q;
        wr_data = wr_data_q;
        rd_addr = rd_addr_q;
    end

    // R9
    wr_evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> !wr_evt);

    // R7
    rd_evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt |=> !rd_evt);

endmodule

// File: rtl/tmr_ctl_decoder.sv
// Turns one sampled write event into per-channel strobes. Channel ports
// produce a load strobe. The control port is split by its target field
// into mode programming, count freezing or a multi-channel read-back.
// Assumes NUM_CH <= 3 so that the target value 3 is free for read-back.
module tmr_ctl_decoder
    import tmr_front_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] load_stb,
    output logic [NUM_CH-1:0] prog_stb,
    output logic [NUM_CH-1:0] latch_stb,
    output logic [2:0]        cw_mode,
    output logic [1:0]        cw_access,
    output logic              cw_bcd,
    output logic              rb_stb,
    output logic [NUM_CH-1:0] rb_sel,
    output logic              rb_count,
    output logic              rb_status
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);
    localparam logic [1:0]        RB_TARGET = 2'b11;

    ctl_byte_t cw;
    logic      ctl_evt;

    // Field view of the captured byte and the control-port qualifier.
    always_comb begin
        cw      = ctl_byte_t'(wr_data);
        ctl_evt = wr_evt && (wr_addr == CTRL_ADDR);
    end

    // One strobe set per channel, chosen by address or by target field.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        always_comb begin
            load_stb[i]  = wr_evt && (wr_addr == ADDR_W'(i));
            prog_stb[i]  = ctl_evt && (cw.target == 2'(i))
                           && (cw.access != ACC_FREEZE);
            latch_stb[i] = ctl_evt && (cw.target == 2'(i))
                           && (cw.access == ACC_FREEZE);
            rb_sel[i]    = wr_data[i+1];
        end
    end

    // Programming fields and read-back request flags.
    always_comb begin
        cw_mode   = fold_mode(cw.mode);
        cw_access = cw.access;
        cw_bcd    = cw.bcd;
        rb_stb    = ctl_evt && (cw.target == RB_TARGET);
        rb_count  = ~wr_data[5];
        rb_status = ~wr_data[4];
    end

    // R6
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_stb, latch_stb, rb_stb}));

    // R4
    mode_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|prog_stb) |-> (cw_mode <= 3'd5));

    // R2
    load_vs_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|load_stb) |-> !(|{prog_stb, latch_stb, rb_stb}));

endmodule

// File: rtl/tmr_rd_path.sv
// Host read path. Drives the addressed channel's byte while a qualified
// read is active, and keeps the bus disabled for the write-only control
// port. Turns the end-of-read event into a per-channel byte strobe.
// Assumes chan_rdata holds each channel's current byte, channel n at n*8.
module tmr_rd_path
    import tmr_front_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    rd_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [NUM_CH*BUS_W-1:0] chan_rdata,
    input  logic                    rd_evt,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [BUS_W-1:0]        dout,
    output logic                    dout_oe,
    output logic [NUM_CH-1:0]       rbyte_stb
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

    logic chan_hit;

    // Output enable and data mux for the addressed channel.
    always_comb begin
        chan_hit = (int'(addr) < NUM_CH);
        dout_oe  = ~cs_n & ~rd_n & chan_hit;
        dout     = '0;
        if (dout_oe) begin
            dout = chan_rdata[int'(addr)*BUS_W +: BUS_W];
        end
    end

    // Byte-consumed strobe for the channel that was read.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_rb
        always_comb rbyte_stb[i] = rd_evt && (rd_addr == ADDR_W'(i));
    end

    // R1
    oe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (!cs_n && !rd_n));

    // R8
    ctrl_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == CTRL_ADDR) |-> !dout_oe);

    // R7
    rbyte_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rbyte_stb));

endmodule

// File: rtl/tmr_host_front.sv
// Host-facing front end of a multi-channel interval timer. It samples
// the bus, decodes writes into channel and control strobes, and serves
// channel reads. Counting and status formatting live in the channels.
// Assumes one system clock and a synchronous active-low reset.
module tmr_host_front
    import tmr_front_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        rd_n,
    input  logic                        wr_n,
    input  logic [1:0]                  addr,
    input  logic [7:0]                  din,
    input  logic [NUM_CH*8-1:0]         chan_rdata,
    output logic [7:0]                  dout,
    output logic                        dout_oe,
    output logic [7:0]                  wr_byte,
    output logic [NUM_CH-1:0]           load_stb,
    output logic [NUM_CH-1:0]           prog_stb,
    output logic [NUM_CH-1:0]           latch_stb,
    output logic [NUM_CH-1:0]           rbyte_stb,
    output logic [2:0]                  cw_mode,
    output logic [1:0]                  cw_access,
    output logic                        cw_bcd,
    output logic                        rb_stb,
    output logic [NUM_CH-1:0]           rb_sel,
    output logic                        rb_count,
    output logic                        rb_status
);

    localparam int ADDR_W = 2;

    logic              wr_evt, rd_evt;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [BUS_W-1:0]  wr_data;

    tmr_bus_sampler #(.ADDR_W(ADDR_W), .DATA_W(BUS_W)) u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .addr    (addr),
        .din     (din),
        .wr_evt  (wr_evt),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_evt  (rd_evt),
        .rd_addr (rd_addr)
    );

    tmr_ctl_decoder #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_evt    (wr_evt),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .load_stb  (load_stb),
        .prog_stb  (prog_stb),
        .latch_stb (latch_stb),
        .cw_mode   (cw_mode),
        .cw_access (cw_access),
        .cw_bcd    (cw_bcd),
        .rb_stb    (rb_stb),
        .rb_sel    (rb_sel),
        .rb_count  (rb_count),
        .rb_status (rb_status)
    );

    tmr_rd_path #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .addr       (addr),
        .chan_rdata (chan_rdata),
        .rd_evt     (rd_evt),
        .rd_addr    (rd_addr),
        .dout       (dout),
        .dout_oe    (dout_oe),
        .rbyte_stb  (rbyte_stb)
    );

    // Byte presented to the channels alongside any write strobe.
    always_comb wr_byte = wr_data;

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !(|{load_stb, prog_stb, latch_stb, rb_stb}));

endmodule

// File: tb/tb_tmr_host_front.sv
module tb_tmr_host_front;

    localparam int NCH = 3;

    // Kind codes: 0 load, 1 program, 2 freeze, 3 read-back
    typedef struct packed {
        logic [1:0] a;
        logic [7:0] d;
        logic [1:0] kind;
        logic [1:0] ch;
        logic [2:0] mode;
        logic [1:0] acc;
        logic       bcd;
        logic [2:0] rbm;
        logic       rbc;
        logic       rbs;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'h5A, 2'd0, 2'd0, 3'd0, 2'd0, 1'b0, 3'b000, 1'b0, 1'b0},
        '{2'd2, 8'hFF, 2'd0, 2'd2, 3'd0, 2'd0, 1'b0, 3'b000, 1'b0, 1'b0},
        '{2'd1, 8'h00, 2'd0, 2'd1, 3'd0, 2'd0, 1'b0, 3'b000, 1'b0, 1'b0},
        '{2'd3, 8'h34, 2'd1, 2'd0, 3'd2, 2'd3, 1'b0, 3'b000, 1'b0, 1'b0},
        '{2'd3, 8'h7D, 2'd1, 2'd1, 3'd2, 2'd3, 1'b1, 3'b000, 1'b0, 1'b0},
        '{2'd3, 8'h9E, 2'd1, 2'd2, 3'd3, 2'd1, 1'b0, 3'b000, 1'b0, 1'b0},
        '{2'd3, 8'h28, 2'd1, 2'd0, 3'd4, 2'd2, 1'b0, 3'b000, 1'b0, 1'b0},
        '{2'd3, 8'h5A, 2'd1, 2'd1, 3'd5, 2'd1, 1'b0, 3'b000, 1'b0, 1'b0},
        '{2'd3, 8'h12, 2'd1, 2'd0, 3'd1, 2'd1, 1'b0, 3'b000, 1'b0, 1'b0},
        '{2'd3, 8'h30, 2'd1, 2'd0, 3'd0, 2'd3, 1'b0, 3'b000, 1'b0, 1'b0},
        '{2'd3, 8'h40, 2'd2, 2'd1, 3'd0, 2'd0, 1'b0, 3'b000, 1'b0, 1'b0},
        '{2'd3, 8'h8F, 2'd2, 2'd2, 3'd0, 2'd0, 1'b0, 3'b000, 1'b0, 1'b0},
        '{2'd3, 8'h06, 2'd2, 2'd0, 3'd0, 2'd0, 1'b0, 3'b000, 1'b0, 1'b0},
        '{2'd3, 8'hC2, 2'd3, 2'd0, 3'd0, 2'd0, 1'b0, 3'b001, 1'b1, 1'b1},
        '{2'd3, 8'hEE, 2'd3, 2'd0, 3'd0, 2'd0, 1'b0, 3'b111, 1'b0, 1'b1},
        '{2'd3, 8'hDC, 2'd3, 2'd0, 3'd0, 2'd0, 1'b0, 3'b110, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] din = '0;
    logic [NCH*8-1:0] chan_rdata = 24'hC3_B2_A1;
    logic [7:0] dout, wr_byte;
    logic dout_oe, cw_bcd, rb_stb, rb_count, rb_status;
    logic [NCH-1:0] load_stb, prog_stb, latch_stb, rbyte_stb, rb_sel;
    logic [2:0] cw_mode;
    logic [1:0] cw_access;

    int tests = 0, fails = 0, cycles = 0;
    int n_load [NCH], n_prog [NCH], n_latch [NCH], n_rbyte [NCH];
    int n_rb, n_oe;
    logic [7:0] c_byte;
    logic [2:0] c_mode, c_rbm;
    logic [1:0] c_acc;
    logic c_bcd, c_rbc, c_rbs;

    tmr_host_front #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .chan_rdata(chan_rdata), .dout(dout),
        .dout_oe(dout_oe), .wr_byte(wr_byte), .load_stb(load_stb),
        .prog_stb(prog_stb), .latch_stb(latch_stb), .rbyte_stb(rbyte_stb),
        .cw_mode(cw_mode), .cw_access(cw_access), .cw_bcd(cw_bcd),
        .rb_stb(rb_stb), .rb_sel(rb_sel), .rb_count(rb_count),
        .rb_status(rb_status)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 50000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        for (int i = 0; i < NCH; i++) begin
            n_load[i] = 0; n_prog[i] = 0; n_latch[i] = 0; n_rbyte[i] = 0;
        end
        n_rb = 0; n_oe = 0;
    endtask

    task automatic sample();
        for (int i = 0; i < NCH; i++) begin
            if (load_stb[i])  begin n_load[i]++;  c_byte = wr_byte; end
            if (prog_stb[i])  begin n_prog[i]++;  c_mode = cw_mode; c_acc = cw_access; c_bcd = cw_bcd; end
            if (latch_stb[i]) n_latch[i]++;
            if (rbyte_stb[i]) n_rbyte[i]++;
        end
        if (rb_stb) begin n_rb++; c_rbm = rb_sel; c_rbc = rb_count; c_rbs = rb_status; end
        if (dout_oe) n_oe++;
    endtask

    int total_strobes;
    task automatic count_all();
        total_strobes = n_rb;
        for (int i = 0; i < NCH; i++)
            total_strobes += n_load[i] + n_prog[i] + n_latch[i] + n_rbyte[i];
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d,
                            input int hold, input logic sel_n);
        clear_counts();
        @(negedge clk);
        cs_n = sel_n; wr_n = 1'b0; addr = a; din = d;
        repeat (hold) begin @(negedge clk); sample(); end
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (3) begin @(negedge clk); sample(); end
    endtask

    initial begin
        clear_counts();
        // R9: reset holds strobes low
        repeat (3) begin @(negedge clk); sample(); end
        count_all();
        check(total_strobes == 0 && !dout_oe, "R9 reset quiet", total_strobes, 0);
        rst_n = 1'b1;

        // Vector walk over channel and control writes
        for (int v = 0; v < NV; v++) begin
            do_write(VECS[v].a, VECS[v].d, 2, 1'b0);
            for (int i = 0; i < NCH; i++) begin
                check(n_load[i] == ((VECS[v].kind == 0 && VECS[v].ch == i) ? 1 : 0),
                      "R2 load count", n_load[i], v);
                check(n_prog[i] == ((VECS[v].kind == 1 && VECS[v].ch == i) ? 1 : 0),
                      "R3 prog count", n_prog[i], v);
                check(n_latch[i] == ((VECS[v].kind == 2 && VECS[v].ch == i) ? 1 : 0),
                      "R5 latch count", n_latch[i], v);
            end
            check(n_rb == ((VECS[v].kind == 3) ? 1 : 0), "R6 readback count", n_rb, v);
            if (VECS[v].kind == 0)
                check(c_byte == VECS[v].d, "R2 wr_byte", c_byte, VECS[v].d);
            if (VECS[v].kind == 1) begin
                check(c_mode == VECS[v].mode, "R4 mode fold", c_mode, VECS[v].mode);
                check(c_acc == VECS[v].acc, "R3 access", c_acc, VECS[v].acc);
                check(c_bcd == VECS[v].bcd, "R3 bcd", c_bcd, VECS[v].bcd);
            end
            if (VECS[v].kind == 3)
                check({c_rbm, c_rbc, c_rbs} == {VECS[v].rbm, VECS[v].rbc, VECS[v].rbs},
                      "R6 readback fields", {c_rbm, c_rbc, c_rbs},
                      {VECS[v].rbm, VECS[v].rbc, VECS[v].rbs});
        end

        // R1: write with chip select high
        do_write(2'd3, 8'h34, 3, 1'b1);
        count_all();
        check(total_strobes == 0, "R1 write ignored", total_strobes, 0);

        // R1: read with chip select high
        clear_counts();
        @(negedge clk); addr = 2'd1; rd_n = 1'b0;
        repeat (3) begin @(negedge clk); sample(); end
        rd_n = 1'b1;
        repeat (3) begin @(negedge clk); sample(); end
        count_all();
        check(n_oe == 0 && total_strobes == 0, "R1 read ignored", n_oe + total_strobes, 0);

        // R9: long held write yields one pulse
        do_write(2'd1, 8'h77, 20, 1'b0);
        check(n_load[1] == 1, "R9 long write single", n_load[1], 1);

        // R9: pulse timing, visible after first sampling edge only
        clear_counts();
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; addr = 2'd2; din = 8'h11;
        check(load_stb == 3'b000, "R9 no early pulse", load_stb, 0);
        @(negedge clk);
        check(load_stb == 3'b100, "R9 pulse cycle", load_stb, 3'b100);
        @(negedge clk);
        check(load_stb == 3'b000, "R9 pulse ends", load_stb, 0);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7: channel reads, one ended by chip select
        for (int c = 0; c < NCH; c++) begin
            clear_counts();
            @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; addr = 2'(c);
            #1;
            check(dout_oe && dout == chan_rdata[c*8 +: 8], "R7 read data",
                  dout, chan_rdata[c*8 +: 8]);
            repeat (4) begin @(negedge clk); sample(); end
            cs_n = 1'b1;
            if (c != 2) rd_n = 1'b1;
            repeat (3) begin @(negedge clk); sample(); end
            rd_n = 1'b1;
            for (int i = 0; i < NCH; i++)
                check(n_rbyte[i] == ((i == c) ? 1 : 0), "R7 rbyte count", n_rbyte[i], c);
        end

        // R8: read at control address
        clear_counts();
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; addr = 2'd3;
        #1;
        check(!dout_oe && dout == 8'h00, "R8 ctrl read disabled", {dout_oe, dout}, 0);
        repeat (3) begin @(negedge clk); sample(); end
        cs_n = 1'b1; rd_n = 1'b1;
        repeat (3) begin @(negedge clk); sample(); end
        count_all();
        check(total_strobes == 0 && n_oe == 0, "R8 ctrl read quiet", total_strobes + n_oe, 0);

        // R9: reset mid-write suppresses the strobe
        clear_counts();
        @(negedge clk); rst_n = 1'b0; cs_n = 1'b0; wr_n = 1'b0; addr = 2'd0;
        repeat (3) begin @(negedge clk); sample(); end
        count_all();
        check(total_strobes == 0, "R9 reset holds strobes", total_strobes, 0);
        cs_n = 1'b1; wr_n = 1'b1; rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule